// File: doc/BRIEF.md
# Brushless Motor Step Event Sequencer

This block follows the three events that make up one electrical step of a brushless DC motor drive. The step opens with commutation (C), continues with the end of demagnetisation (D), and closes with the back-EMF zero-crossing (Z). A free-running step timer measures the step and is cleared by every Z event. On each event the block latches the timer value into a capture register, so that software can compute compare values from the timing of the previous event.

Commutation always comes from a compare register. D and Z come either from hardware inputs or, when their simulation bits are set, from compare registers of their own. Software arms such a compare by writing it. A demagnetisation compare is accepted only after the C event of the current step. A zero-crossing compare is accepted only after the D event. An armed compare fires once, when the timer reaches its value.

In simulated-commutation mode the step no longer has to pass through D before the next C. Several commutations can follow one another, while any D and Z events still have to arrive in D-then-Z order. Entering this mode disarms the commutation compare, so that a stale value cannot fire. Every event gives a one-cycle pulse and sets a sticky flag that software clears by writing 1.

Top module: `commSeq`

## Requirements
- R1: After reset the step timer, the capture register, all event pulses and all flags are 0. The sequencer waits for C with every compare disarmed and every mode bit clear.
- R2: In normal mode a hardware D (`hwDemag` high for a cycle) is taken only while D is awaited, which means after C. A hardware Z is taken only while Z is awaited, which means after D. Pulses on these inputs at any other time change no output.
- R3: The step timer adds 1 each cycle and holds at all ones. The cycle after a Z event it reads 0.
- R4: The write port decodes `wrAddr` as follows:
  - 0: mode bits. Bit 0 selects simulated D, bit 1 selects simulated Z, bit 2 selects simulated commutation.
  - 1: commutation compare.
  - 2: demagnetisation compare.
  - 3: zero-crossing compare.
  - 4: flag clear. Bit 0 clears C, bit 1 clears D, bit 2 clears Z.
- R5: With simulated D selected, D fires when the timer is at or above the demagnetisation compare. That compare must have been written while D was awaited. A write at any other time does not arm it. Each arming gives one D at most.
- R6: With simulated Z selected, Z fires when the timer is at or above the zero-crossing compare. That compare must have been written while Z was awaited. A write at any other time does not arm it. Each arming gives one Z at most.
- R7: Any write to the commutation compare arms it. In normal mode it fires C only while C is awaited, once the timer is at or above its value, and it is then disarmed.
- R8: In simulated-commutation mode an armed commutation compare fires in any phase. After it fires, D is awaited. C events may follow back to back. A C event wins over a D or Z event due in the same cycle.
- R9: A write that sets the simulated-commutation bit while it was clear disarms the commutation compare. No C event follows until the commutation compare is written again, whatever the timer value.
- R10: Each event gives a one-cycle pulse (`evtComm`, `evtDemag`, `evtZero`) the cycle after it is detected. It also sets the matching bit of `irqFlags`, where bit 0 is C, bit 1 is D and bit 2 is Z. A flag stays set until a 1 is written to its bit at address 4. When a set and a clear of the same flag land in the same cycle, the set wins.
- R11: On each event `captureVal` takes the step timer value of the cycle in which the event was detected.
- R12: Simulated D and simulated Z can both be used within one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | TIMER_W | Write data |
| hwDemag | input | 1 | Hardware end-of-demagnetisation event |
| hwZero | input | 1 | Hardware zero-crossing event |
| evtComm | output | 1 | Commutation event pulse |
| evtDemag | output | 1 | Demagnetisation event pulse |
| evtZero | output | 1 | Zero-crossing event pulse |
| irqFlags | output | 3 | Sticky event flags (C, D, Z) |
| captureVal | output | TIMER_W | Timer value captured at the last event |
| stepTimer | output | TIMER_W | Current step timer |

## Verification
The bench builds the block with `TIMER_W` = 8. With this width the timer saturates after 255 cycles, so a long idle stretch without a Z event shows the hold at all ones. Compare values written near that limit show the greater-or-equal rule firing on a saturated timer. The short width also keeps every simulated compare within a few cycles of the current timer value. Sequences in both normal and simulated-commutation mode therefore fit in a compact run.

// File: rtl/commSeqPkg.sv
package commSeqPkg;

  // Phase of the step: which event is awaited next
  typedef enum logic [1:0] {
    PH_WAIT_C = 2'd0,
    PH_WAIT_D = 2'd1,
    PH_WAIT_Z = 2'd2
  } phase_e;

  // Event indices, shared by every per-event vector
  localparam int EV_C   = 0;
  localparam int EV_D   = 1;
  localparam int EV_Z   = 2;
  localparam int NUM_EV = 3;

  // Register addresses
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP_C = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP_D = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMP_Z = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CLR   = 3'd4;

  // Mode bit positions
  localparam int MODE_SIM_D = 0;
  localparam int MODE_SIM_Z = 1;
  localparam int MODE_SIM_C = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_EV-1:0] fire;   // event detected this cycle
    logic [NUM_EV-1:0] load;   // load compare value from write data
    logic [NUM_EV-1:0] clr;    // write-one-to-clear mask for flags
  } strobe_t;

endpackage

// File: rtl/commSeqCtrl.sv
module commSeqCtrl
  import commSeqPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [NUM_EV-1:0]         wrBits,
  input  logic                      hwDemag,
  input  logic                      hwZero,
  input  logic [NUM_EV-1:0]         hit,
  output strobe_t                   strb
);

  phase_e            phase, phaseNext;
  logic [NUM_EV-1:0] modeBits, modeNext;
  logic [NUM_EV-1:0] arm, armNext;
  logic [NUM_EV-1:0] wrCmp;
  logic              wrMode, wrClr;
  logic              candC, candD, candZ;
  logic              fireC, fireD, fireZ;
  logic              simD, simZ, simC;

  assign simD = modeBits[MODE_SIM_D];
  assign simZ = modeBits[MODE_SIM_Z];
  assign simC = modeBits[MODE_SIM_C];

  assign wrMode = wrEn && (wrAddr == ADDR_MODE);
  assign wrClr  = wrEn && (wrAddr == ADDR_CLR);

  // One compare-write decode per event
  for (genvar g = 0; g < NUM_EV; g++) begin : gWrDec
    localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_CMP_C + ADDR_W'(g);
    assign wrCmp[g] = wrEn && (wrAddr == CMP_ADDR);
  end

  // Event detection
  always_comb begin
    candC = arm[EV_C] && hit[EV_C] && (simC || (phase == PH_WAIT_C));
    candD = (phase == PH_WAIT_D) &&
            (simD ? (arm[EV_D] && hit[EV_D]) : hwDemag);
    candZ = (phase == PH_WAIT_Z) &&
            (simZ ? (arm[EV_Z] && hit[EV_Z]) : hwZero);
    // Commutation has priority over a D or Z due in the same cycle
    fireC = candC;
    fireD = candD && !candC;
    fireZ = candZ && !candC;
  end

  // Phase sequencing
  always_comb begin
    phaseNext = phase;
    if (fireC)      phaseNext = PH_WAIT_D;
    else if (fireD) phaseNext = PH_WAIT_Z;
    else if (fireZ) phaseNext = PH_WAIT_C;
  end

  // Mode bits and compare arming
  always_comb begin
    modeNext = wrMode ? wrBits : modeBits;
    armNext  = arm;

    if (wrCmp[EV_C])                          armNext[EV_C] = 1'b1;
    else if (fireC)                           armNext[EV_C] = 1'b0;
    else if (wrMode && wrBits[MODE_SIM_C] && !simC)
                                              armNext[EV_C] = 1'b0;

    if (fireC || fireD)                       armNext[EV_D] = 1'b0;
    else if (wrCmp[EV_D] && phase == PH_WAIT_D) armNext[EV_D] = 1'b1;

    if (fireC || fireZ)                       armNext[EV_Z] = 1'b0;
    else if (wrCmp[EV_Z] && phase == PH_WAIT_Z) armNext[EV_Z] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_WAIT_C;
      modeBits <= '0;
      arm      <= '0;
    end else begin
      phase    <= phaseNext;
      modeBits <= modeNext;
      arm      <= armNext;
    end
  end

  always_comb begin
    strb.fire        = '0;
    strb.fire[EV_C]  = fireC;
    strb.fire[EV_D]  = fireD;
    strb.fire[EV_Z]  = fireZ;
    strb.load        = wrCmp;
    strb.clr         = wrClr ? wrBits : '0;
  end

  AST_D_LEADS_TO_Z: assert property (@(posedge clk) disable iff (!rstN)
    fireD |=> (phase == PH_WAIT_Z)); // R2
  AST_SIMD_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (fireD && simD) |=> !arm[EV_D]); // R5
  AST_SIMZ_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (fireZ && simZ) |=> !arm[EV_Z]); // R6
  AST_COMM_NORMAL_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (fireC && !simC) |-> (phase == PH_WAIT_C)); // R7
  AST_SIMC_AFTER_C: assert property (@(posedge clk) disable iff (!rstN)
    (fireC && simC) |=> (phase == PH_WAIT_D)); // R8
  AST_SIMC_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(simC) |-> !arm[EV_C]); // R9

endmodule

// File: rtl/commSeqDatapath.sv
module commSeqDatapath
  import commSeqPkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [TIMER_W-1:0]    wrData,
  output logic [NUM_EV-1:0]     hit,
  output logic [NUM_EV-1:0]     evtPulse,
  output logic [NUM_EV-1:0]     irqFlags,
  output logic [TIMER_W-1:0]    stepTimer,
  output logic [TIMER_W-1:0]    captureVal
);

  localparam logic [TIMER_W-1:0] TIMER_MAX = '1;

  logic [TIMER_W-1:0] timerNext;

  // Step timer: saturating count, cleared by Z
  always_comb begin
    if (strb.fire[EV_Z])            timerNext = '0;
    else if (stepTimer == TIMER_MAX) timerNext = TIMER_MAX;
    else                             timerNext = stepTimer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepTimer  <= '0;
      captureVal <= '0;
    end else begin
      stepTimer <= timerNext;
      if (|strb.fire) captureVal <= stepTimer;
    end
  end

  // One compare channel, pulse and flag per event
  for (genvar g = 0; g < NUM_EV; g++) begin : gChan
    logic [TIMER_W-1:0] cmpVal;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpVal      <= '0;
        evtPulse[g] <= 1'b0;
        irqFlags[g] <= 1'b0;
      end else begin
        if (strb.load[g]) cmpVal <= wrData;
        evtPulse[g] <= strb.fire[g];
        irqFlags[g] <= strb.fire[g] || (irqFlags[g] && !strb.clr[g]);
      end
    end

    assign hit[g] = (stepTimer >= cmpVal);

    AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[g] |-> irqFlags[g]); // R10
  end

  AST_Z_CLEARS_TIMER: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire[EV_Z] |=> (stepTimer == '0)); // R3
  AST_TIMER_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (stepTimer == TIMER_MAX && !strb.fire[EV_Z]) |=> (stepTimer == TIMER_MAX)); // R3
  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.fire) |=> (captureVal == $past(stepTimer))); // R11

endmodule

// File: rtl/commSeq.sv
module commSeq
  import commSeqPkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [TIMER_W-1:0] wrData,
  input  logic               hwDemag,
  input  logic               hwZero,
  output logic               evtComm,
  output logic               evtDemag,
  output logic               evtZero,
  output logic [2:0]         irqFlags,
  output logic [TIMER_W-1:0] captureVal,
  output logic [TIMER_W-1:0] stepTimer
);

  strobe_t           strb;
  logic [NUM_EV-1:0] hit;
  logic [NUM_EV-1:0] evtPulse;

  commSeqCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrBits  (wrData[NUM_EV-1:0]),
    .hwDemag (hwDemag),
    .hwZero  (hwZero),
    .hit     (hit),
    .strb    (strb)
  );

  commSeqDatapath #(.TIMER_W(TIMER_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .hit        (hit),
    .evtPulse   (evtPulse),
    .irqFlags   (irqFlags),
    .stepTimer  (stepTimer),
    .captureVal (captureVal)
  );

  assign evtComm  = evtPulse[EV_C];
  assign evtDemag = evtPulse[EV_D];
  assign evtZero  = evtPulse[EV_Z];

endmodule

// File: tb/commSeq_test.sv
module commSeq_test;

  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN;
  logic         wrEn;
  logic [2:0]   wrAddr;
  logic [W-1:0] wrData;
  logic         hwDemag, hwZero;
  logic         evtComm, evtDemag, evtZero;
  logic [2:0]   irqFlags;
  logic [W-1:0] captureVal, stepTimer;

  always #10 clk = ~clk;  // 50 MHz

  commSeq #(.TIMER_W(W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hwDemag(hwDemag), .hwZero(hwZero),
    .evtComm(evtComm), .evtDemag(evtDemag), .evtZero(evtZero),
    .irqFlags(irqFlags), .captureVal(captureVal), .stepTimer(stepTimer)
  );

  // Reference model state (phase: 0 awaits C, 1 awaits D, 2 awaits Z)
  int mTimer, mPhase, mCap;
  int mCmp [3];
  bit mArm [3];
  bit mEn  [3];   // 0 sim D, 1 sim Z, 2 sim C
  bit [2:0] mFlags, mEvt;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic check(string req, int act, int exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R3",  stepTimer, mTimer, "stepTimer");
    check("R11", captureVal, mCap, "captureVal");
    check("R10", irqFlags, mFlags, "irqFlags");
    check("R2",  {evtZero, evtDemag, evtComm}, mEvt, "event pulses");
  endtask

  task automatic modelReset();
    mTimer = 0; mPhase = 0; mCap = 0; mFlags = 0; mEvt = 0;
    for (int i = 0; i < 3; i++) begin mCmp[i] = 0; mArm[i] = 0; mEn[i] = 0; end
  endtask

  // One clock: drive at negedge, predict, compare at the next negedge
  task automatic cyc(bit we, int addr, int data, bit hd, bit hz);
    bit cC, cD, cZ, fC, fD, fZ;
    bit [2:0] clr;
    bit nArm [3];
    wrEn = we; wrAddr = 3'(addr); wrData = W'(data); hwDemag = hd; hwZero = hz;
    cC = mArm[0] && (mTimer >= mCmp[0]) && (mEn[2] || mPhase == 0);
    cD = (mPhase == 1) && (mEn[0] ? (mArm[1] && mTimer >= mCmp[1]) : hd);
    cZ = (mPhase == 2) && (mEn[1] ? (mArm[2] && mTimer >= mCmp[2]) : hz);
    fC = cC; fD = cD && !cC; fZ = cZ && !cC;
    nArm = mArm;
    if (we && addr == 1) nArm[0] = 1;
    else if (fC) nArm[0] = 0;
    else if (we && addr == 0 && data[2] && !mEn[2]) nArm[0] = 0;  // R9
    if (fC || fD) nArm[1] = 0;
    else if (we && addr == 2 && mPhase == 1) nArm[1] = 1;
    if (fC || fZ) nArm[2] = 0;
    else if (we && addr == 3 && mPhase == 2) nArm[2] = 1;
    clr = (we && addr == 4) ? 3'(data) : 3'b000;
    @(posedge clk);
    @(negedge clk);
    if (fC || fD || fZ) mCap = mTimer;
    if (fZ) mTimer = 0; else if (mTimer < MAXV) mTimer++;
    if (fC) mPhase = 1; else if (fD) mPhase = 2; else if (fZ) mPhase = 0;
    mEvt = {fZ, fD, fC};
    mFlags = (mFlags & ~clr) | mEvt;
    if (we && addr >= 1 && addr <= 3) mCmp[addr-1] = data & MAXV;
    if (we && addr == 0) begin mEn[0] = data[0]; mEn[1] = data[1]; mEn[2] = data[2]; end
    mArm = nArm;
    compareAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic wr(int addr, int data);
    cyc(1, addr, data, 0, 0);
  endtask

  task automatic waitPhase(int p);
    for (int i = 0; i < 600 && mPhase != p; i++) cyc(0, 0, 0, 0, 0);
  endtask

  function automatic int ahead(int d);
    return (mTimer + d > MAXV) ? MAXV : mTimer + d;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    summary();
  end

  initial begin
    rstN = 0; wrEn = 0; wrAddr = 0; wrData = 0; hwDemag = 0; hwZero = 0;
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state
    compareAll();
    rstN = 1;
    idle(2);

    // R2, R7: hardware D/Z out of order are ignored; compare-driven C
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);
    wr(1, ahead(5));
    waitPhase(1);
    cyc(0, 0, 0, 0, 1);          // Z before D: ignored
    idle(2);
    cyc(0, 0, 0, 1, 0);          // D accepted
    cyc(0, 0, 0, 1, 0);          // second D ignored
    idle(2);
    cyc(0, 0, 0, 0, 1);          // Z accepted, R3 timer clears
    idle(3);

    // R4, R5, R6, R12: simulated D and simulated Z in one step
    wr(0, 3);
    wr(2, 1);                    // R5: write while awaiting C does not arm
    wr(1, ahead(4));
    waitPhase(1);
    idle(3);                     // no D without arming
    cyc(0, 0, 0, 1, 0);          // hardware D ignored in simulated-D mode
    wr(3, 0);                    // R6: write while awaiting D does not arm
    wr(2, ahead(3));
    waitPhase(2);
    idle(2);
    wr(3, ahead(5));
    waitPhase(0);
    idle(3);

    // R3: saturation of the step timer
    idle(300);

    // R10: write-one-to-clear, and set winning over clear
    wr(4, 5);
    wr(1, 0);
    wr(4, 1);                    // C fires in this cycle; set wins
    idle(2);
    wr(4, 7);
    idle(2);

    // R9: entering simulated-commutation disarms C
    wr(1, 200);
    wr(0, 4);
    idle(6);                     // timer >= 200 but no C
    cyc(0, 0, 0, 1, 0);          // hardware D
    cyc(0, 0, 0, 0, 1);          // hardware Z
    // R8: back-to-back simulated commutations
    wr(1, 3);
    waitPhase(1);
    wr(1, ahead(2));
    idle(4);
    wr(1, ahead(2));
    idle(4);
    wr(1, 0);
    cyc(0, 0, 0, 1, 0);          // C and D due together: C wins (R8)
    idle(2);
    cyc(0, 0, 0, 1, 0);
    idle(2);
    cyc(0, 0, 0, 0, 1);
    idle(3);
    wr(4, 7);
    idle(3);

    summary();
  end

endmodule